// File: doc/BRIEF.md
# Quad-Data-Rate Burst-Four SRAM Core

This block is a synthesizable behavioural model of a memory with separate read and write ports. Each port moves four words per transaction, and each transaction holds the port for two clock cycles. Both ports sample their active-low select on the rising clock edge, and they run independently. Each clock cycle carries two data beats per direction. To keep the model on one clock, the beats appear side by side: beat 0 holds the even word of the pair and beat 1 holds the odd word.

Write data is not placed in the array directly. A capture stage collects the first half of a burst. The complete burst then waits in a pending register, and it is merged into the array only when the next burst completes or when reset arrives. A read compares its address with the capture stage and the pending register, then builds each byte lane from the newest holder of that lane. It therefore never returns stale array contents. A select that arrives while the same port is still busy with a burst is dropped.

Top module: `qdr4_sram_core`

## Requirements
- R1: `rd_n` and `wr_n` are active low and sampled on the rising clock edge. A read and a write can both be accepted on the same edge. A read accepted on the same edge as a write returns the data from before that write.
- R2: For a burst at burst address A, the words are array words 4A+0 to 4A+3. Words 0 and 1 travel in the first data cycle, on beat 0 and beat 1. Words 2 and 3 travel in the second data cycle, in the same beat order.
- R3: A read select sampled on the edge right after an accepted read is ignored. A read select on the edge after that is accepted, so read bursts can follow each other with no gap.
- R4: A write select sampled on the edge right after an accepted write is ignored, and it changes no memory contents.
- R5: For a read accepted on edge T, `rd_valid` is high with words 0 and 1 after edge T+1, and with words 2 and 3 after edge T+2.
- R6: For a write accepted on edge T, words 0 and 1 and their masks are sampled on edge T+1. Words 2 and 3 and their masks are sampled on edge T+2. Data on the bus outside those edges has no effect.
- R7: Mask bit b of a beat, active low, enables byte lane b (bits b*BYTE_W and up) of that beat's word only. A lane whose mask bit is high keeps its previous value.
- R8: A read returns the result of every write accepted on an earlier edge, including a write to the same burst accepted on the edge just before. This holds while that write is still in the capture stage or the pending register.
- R9: Forwarding works per byte lane. A lane written by a held burst comes from that burst, and any other lane comes from older contents.
- R10: `rd_valid` is low on every cycle that does not carry read data.
- R11: Synchronous active-high `rst` clears both ports' burst state and `rd_valid`. Memory contents, including a completed write still pending, are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_n | input | 1 | Read select, active low |
| rd_addr | input | AW | Burst address of the read |
| wr_n | input | 1 | Write select, active low |
| wr_addr | input | AW | Burst address of the write |
| wd_beat0 | input | DATA_W | Write data, even word of the current pair |
| wd_beat1 | input | DATA_W | Write data, odd word of the current pair |
| wbe_n_beat0 | input | BYTES | Active-low byte masks for wd_beat0 |
| wbe_n_beat1 | input | BYTES | Active-low byte masks for wd_beat1 |
| rd_beat0 | output | DATA_W | Read data, even word of the current pair |
| rd_beat1 | output | DATA_W | Read data, odd word of the current pair |
| rd_valid | output | 1 | High while rd_beat0/rd_beat1 carry burst data |

## Verification
The assertions assume four things about the inputs. The write data bus carries the accepted burst's words on exactly the two edges after acceptance. Reset is raised only when no write burst is mid-transfer. Reset is held for at least three cycles, so that `$past` lookbacks stay inside the reset window. The array has no reset, so every burst is written before it is read. The stimulus keeps to these rules by tracking acceptance in the bench, driving the held burst's words only in its two data cycles, and filling every burst in full before reading it. It also raises reset only after the write port has gone idle. Outside the data cycles the bus carries random words and masks, so any sampling at the wrong edge shows up in later reads. Random addresses stay within a window of eight bursts, which makes collisions between reads, captured writes and pending writes frequent.

// File: rtl/qdr4_pkg.sv
`timescale 1ns/1ps
package qdr4_pkg;
   // words moved by one transaction
   localparam int BURST_LEN  = 4;
   // words carried per clock cycle (two edges)
   localparam int HALF_WORDS = 2;
endpackage

// File: rtl/qdr4_burst_seq.sv
`timescale 1ns/1ps
// Per-port burst sequencer: accepts a select, then holds the port for two cycles.
module qdr4_burst_seq #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_n,
   input  logic [AW-1:0] addr,
   output logic          accept,
   output logic          first_half,
   output logic          second_half,
   output logic [AW-1:0] addr_q
);

   // a select is taken only when the port is not in its first busy cycle
   assign accept = !rst && !req_n && !first_half;

   always_ff @(posedge clk) begin
      if (rst) begin
         first_half  <= 1'b0;
         second_half <= 1'b0;
      end else begin
         first_half  <= accept;
         second_half <= first_half;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) addr_q <= addr;
   end

   // R3, R4
   acc_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      accept |=> !accept);

endmodule

// File: rtl/qdr4_write_hold.sv
`timescale 1ns/1ps
// Write capture stage plus pending burst register feeding the array.
module qdr4_write_hold
   import qdr4_pkg::*;
#(
   parameter int AW     = 6,
   parameter int BYTE_W = 9,
   parameter int BYTES  = 2,
   localparam int DW    = BYTE_W * BYTES
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                cap_en,
   input  logic                                fin_en,
   input  logic [AW-1:0]                       in_addr,
   input  logic [DW-1:0]                       beat0,
   input  logic [DW-1:0]                       beat1,
   input  logic [BYTES-1:0]                    be_n0,
   input  logic [BYTES-1:0]                    be_n1,
   output logic                                cap_vld,
   output logic [AW-1:0]                       cap_addr,
   output logic [HALF_WORDS-1:0][DW-1:0]       cap_data,
   output logic [HALF_WORDS-1:0][BYTES-1:0]    cap_be,
   output logic                                pend_vld,
   output logic [AW-1:0]                       pend_addr,
   output logic [BURST_LEN-1:0][DW-1:0]        pend_data,
   output logic [BURST_LEN-1:0][BYTES-1:0]     pend_be,
   output logic                                commit
);

   // the held burst drains when replaced, or when reset arrives
   assign commit = pend_vld && (fin_en || rst);

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_vld  <= 1'b0;
         pend_vld <= 1'b0;
      end else begin
         if (cap_en)      cap_vld <= 1'b1;
         else if (fin_en) cap_vld <= 1'b0;
         if (fin_en)      pend_vld <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst && cap_en) begin
         cap_addr    <= in_addr;
         cap_data[0] <= beat0;
         cap_data[1] <= beat1;
         cap_be[0]   <= ~be_n0;
         cap_be[1]   <= ~be_n1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst && fin_en) begin
         pend_addr    <= cap_addr;
         pend_data[0] <= cap_data[0];
         pend_data[1] <= cap_data[1];
         pend_data[2] <= beat0;
         pend_data[3] <= beat1;
         pend_be[0]   <= cap_be[0];
         pend_be[1]   <= cap_be[1];
         pend_be[2]   <= ~be_n0;
         pend_be[3]   <= ~be_n1;
      end
   end

   // R6
   half_order_chk: assert property (@(posedge clk) disable iff (rst)
      fin_en |-> cap_vld);

   // R8
   pend_load_chk: assert property (@(posedge clk) disable iff (rst)
      fin_en |=> pend_vld);

endmodule

// File: rtl/qdr4_lane_merge.sv
`timescale 1ns/1ps
// Per-byte pick of one read word: capture stage, then pending burst, then array.
module qdr4_lane_merge #(
   parameter int BYTE_W = 9,
   parameter int BYTES  = 2,
   localparam int DW    = BYTE_W * BYTES
) (
   input  logic [DW-1:0]    arr_word,
   input  logic             cap_hit,
   input  logic [DW-1:0]    cap_word,
   input  logic [BYTES-1:0] cap_be,
   input  logic             pend_hit,
   input  logic [DW-1:0]    pend_word,
   input  logic [BYTES-1:0] pend_be,
   output logic [DW-1:0]    out_word
);

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      always_comb begin
         if (cap_hit && cap_be[b])
            out_word[b*BYTE_W +: BYTE_W] = cap_word[b*BYTE_W +: BYTE_W];
         else if (pend_hit && pend_be[b])
            out_word[b*BYTE_W +: BYTE_W] = pend_word[b*BYTE_W +: BYTE_W];
         else
            out_word[b*BYTE_W +: BYTE_W] = arr_word[b*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/qdr4_sram_core.sv
`timescale 1ns/1ps
// Separate-port burst-four SRAM core with write holding and read forwarding.
module qdr4_sram_core
   import qdr4_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int BYTE_W  = 9,
   parameter int BYTES   = 2,
   localparam int DATA_W = BYTE_W * BYTES,
   localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_n,
   input  logic [AW-1:0]     rd_addr,
   input  logic              wr_n,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wd_beat0,
   input  logic [DATA_W-1:0] wd_beat1,
   input  logic [BYTES-1:0]  wbe_n_beat0,
   input  logic [BYTES-1:0]  wbe_n_beat1,
   output logic [DATA_W-1:0] rd_beat0,
   output logic [DATA_W-1:0] rd_beat1,
   output logic              rd_valid
);

   // elaboration-time parameter checks
   if (BYTE_W < 1) begin : g_bad_byte_w
      $error("qdr4_sram_core: BYTE_W must be at least 1");
   end
   if (BYTES < 1) begin : g_bad_bytes
      $error("qdr4_sram_core: BYTES must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("qdr4_sram_core: DEPTH must be a power of two, at least 2");
   end

   // port sequencers
   logic          rd_acc, rd_first, rd_second;
   logic [AW-1:0] rd_addr_q;
   logic          wr_acc, wr_first, wr_second;
   logic [AW-1:0] wr_addr_q;

   qdr4_burst_seq #(.AW(AW)) u_rd_seq (
      .clk         (clk),
      .rst         (rst),
      .req_n       (rd_n),
      .addr        (rd_addr),
      .accept      (rd_acc),
      .first_half  (rd_first),
      .second_half (rd_second),
      .addr_q      (rd_addr_q)
   );

   qdr4_burst_seq #(.AW(AW)) u_wr_seq (
      .clk         (clk),
      .rst         (rst),
      .req_n       (wr_n),
      .addr        (wr_addr),
      .accept      (wr_acc),
      .first_half  (wr_first),
      .second_half (wr_second),
      .addr_q      (wr_addr_q)
   );

   // write holding path
   logic                                 cap_vld, pend_vld, commit;
   logic [AW-1:0]                        cap_addr, pend_addr;
   logic [HALF_WORDS-1:0][DATA_W-1:0]    cap_data;
   logic [HALF_WORDS-1:0][BYTES-1:0]     cap_be;
   logic [BURST_LEN-1:0][DATA_W-1:0]     pend_data;
   logic [BURST_LEN-1:0][BYTES-1:0]      pend_be;

   qdr4_write_hold #(.AW(AW), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_hold (
      .clk       (clk),
      .rst       (rst),
      .cap_en    (wr_first),
      .fin_en    (wr_second),
      .in_addr   (wr_addr_q),
      .beat0     (wd_beat0),
      .beat1     (wd_beat1),
      .be_n0     (wbe_n_beat0),
      .be_n1     (wbe_n_beat1),
      .cap_vld   (cap_vld),
      .cap_addr  (cap_addr),
      .cap_data  (cap_data),
      .cap_be    (cap_be),
      .pend_vld  (pend_vld),
      .pend_addr (pend_addr),
      .pend_data (pend_data),
      .pend_be   (pend_be),
      .commit    (commit)
   );

   // storage array, one entry per burst, no reset
   logic [BURST_LEN-1:0][DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (commit) begin
         for (int k = 0; k < BURST_LEN; k++) begin
            for (int b = 0; b < BYTES; b++) begin
               if (pend_be[k][b])
                  mem[pend_addr][k][b*BYTE_W +: BYTE_W] <= pend_data[k][b*BYTE_W +: BYTE_W];
            end
         end
      end
   end

   // read side: forwarding merge per word
   logic [BURST_LEN-1:0][DATA_W-1:0] arr_rd;
   logic [BURST_LEN-1:0][DATA_W-1:0] merged;
   logic                             cap_hit, pend_hit;

   assign arr_rd   = mem[rd_addr_q];
   assign cap_hit  = cap_vld  && (cap_addr  == rd_addr_q);
   assign pend_hit = pend_vld && (pend_addr == rd_addr_q);

   for (genvar k = 0; k < BURST_LEN; k++) begin : g_word
      if (k < HALF_WORDS) begin : g_with_cap
         qdr4_lane_merge #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_merge (
            .arr_word  (arr_rd[k]),
            .cap_hit   (cap_hit),
            .cap_word  (cap_data[k]),
            .cap_be    (cap_be[k]),
            .pend_hit  (pend_hit),
            .pend_word (pend_data[k]),
            .pend_be   (pend_be[k]),
            .out_word  (merged[k])
         );
      end else begin : g_no_cap
         qdr4_lane_merge #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_merge (
            .arr_word  (arr_rd[k]),
            .cap_hit   (1'b0),
            .cap_word  ({DATA_W{1'b0}}),
            .cap_be    ({BYTES{1'b0}}),
            .pend_hit  (pend_hit),
            .pend_word (pend_data[k]),
            .pend_be   (pend_be[k]),
            .out_word  (merged[k])
         );
      end
   end

   // output registers
   logic [DATA_W-1:0] nxt_b0, nxt_b1;

   always_comb begin
      nxt_b0 = rd_second ? merged[2] : merged[0];
      nxt_b1 = rd_second ? merged[3] : merged[1];
   end

   always_ff @(posedge clk) begin
      if (rst) rd_valid <= 1'b0;
      else     rd_valid <= rd_first || rd_second;
   end

   always_ff @(posedge clk) begin
      if (rd_first || rd_second) begin
         rd_beat0 <= nxt_b0;
         rd_beat1 <= nxt_b1;
      end
   end

   // R1
   dual_start_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_n && !wr_n && !rd_first && !wr_first) |=> (rd_first && wr_first));

   // R5
   rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
      rd_acc |=> ##1 rd_valid ##1 rd_valid);

   // R10
   rd_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> ($past(rd_acc, 2) || $past(rd_acc, 3)));

   // R11
   rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !rd_valid);

endmodule

// File: tb/qdr4_sram_core_bench.sv
`timescale 1ns/1ps
module qdr4_sram_core_bench;
   localparam int DEPTH  = 64;
   localparam int BYTE_W = 9;
   localparam int BYTES  = 2;
   localparam int DW     = BYTE_W * BYTES;
   localparam int AW     = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              rd_n = 1'b1, wr_n = 1'b1;
   logic [AW-1:0]     rd_addr = '0, wr_addr = '0;
   logic [DW-1:0]     wd_beat0 = '0, wd_beat1 = '0;
   logic [BYTES-1:0]  wbe_n_beat0 = '1, wbe_n_beat1 = '1;
   logic [DW-1:0]     rd_beat0, rd_beat1;
   logic              rd_valid;

   always #4 clk = ~clk;

   qdr4_sram_core #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_qdr4_sram_core (
      .clk         (clk),
      .rst         (rst),
      .rd_n        (rd_n),
      .rd_addr     (rd_addr),
      .wr_n        (wr_n),
      .wr_addr     (wr_addr),
      .wd_beat0    (wd_beat0),
      .wd_beat1    (wd_beat1),
      .wbe_n_beat0 (wbe_n_beat0),
      .wbe_n_beat1 (wbe_n_beat1),
      .rd_beat0    (rd_beat0),
      .rd_beat1    (rd_beat1),
      .rd_valid    (rd_valid)
   );

   // bench model state
   logic [DW-1:0]    mdl [DEPTH*4];
   bit               slot_v [4];
   logic [DW-1:0]    slot_d0 [4];
   logic [DW-1:0]    slot_d1 [4];
   logic [DW-1:0]    pw [4];
   logic [BYTES-1:0] pm [4];
   bit               m_rbusy = 1'b0;
   int               m_wph = 0;
   int               mask_mode = 0;
   int               edge_n = 0;
   int               checks = 0;
   int               errors = 0;
   bit               done = 1'b0;
   string            cur_req = "R11";

   always @(posedge clk) edge_n <= edge_n + 1;

   // expected word after a masked write (active-low lane masks)
   function automatic logic [DW-1:0] merge_word(input logic [DW-1:0] old_w,
                                                input logic [DW-1:0] new_w,
                                                input logic [BYTES-1:0] be_n);
      logic [DW-1:0] r;
      r = old_w;
      for (int b = 0; b < BYTES; b++)
         if (!be_n[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
      return r;
   endfunction

   task automatic check_out();
      int s;
      s = (edge_n - 1) & 3;
      checks++;
      if (slot_v[s]) begin
         if (rd_valid !== 1'b1 || rd_beat0 !== slot_d0[s] || rd_beat1 !== slot_d1[s]) begin
            errors++;
            $display("FAIL %s: rd_valid=%b data=%h_%h expected rd_valid=1 data=%h_%h",
                     cur_req, rd_valid, rd_beat1, rd_beat0, slot_d1[s], slot_d0[s]);
         end
      end else if (rd_valid !== 1'b0) begin
         errors++;
         $display("FAIL R10 (%s): rd_valid=%b expected 0", cur_req, rd_valid);
      end
      slot_v[s] = 1'b0;
   endtask

   task automatic step(input bit rq, input int ra, input bit wq, input int wa);
      bit racc, wacc;
      int s1, s2;
      @(negedge clk);
      check_out();
      rd_n    = !rq;
      rd_addr = ra[AW-1:0];
      wr_n    = !wq;
      wr_addr = wa[AW-1:0];
      if (m_wph == 1) begin
         wd_beat0 = pw[0]; wd_beat1 = pw[1]; wbe_n_beat0 = pm[0]; wbe_n_beat1 = pm[1];
      end else if (m_wph == 2) begin
         wd_beat0 = pw[2]; wd_beat1 = pw[3]; wbe_n_beat0 = pm[2]; wbe_n_beat1 = pm[3];
      end else begin
         wd_beat0 = DW'($urandom); wd_beat1 = DW'($urandom);
         wbe_n_beat0 = BYTES'($urandom); wbe_n_beat1 = BYTES'($urandom);
      end
      racc = rq && !m_rbusy;
      wacc = wq && (m_wph != 1);
      if (racc) begin
         s1 = (edge_n + 1) & 3;
         s2 = (edge_n + 2) & 3;
         slot_v[s1] = 1'b1; slot_d0[s1] = mdl[ra*4 + 0]; slot_d1[s1] = mdl[ra*4 + 1];
         slot_v[s2] = 1'b1; slot_d0[s2] = mdl[ra*4 + 2]; slot_d1[s2] = mdl[ra*4 + 3];
      end
      if (wacc) begin
         for (int k = 0; k < 4; k++) begin
            pw[k] = DW'($urandom);
            pm[k] = (mask_mode == 0) ? '0 : BYTES'($urandom);
            mdl[wa*4 + k] = merge_word(mdl[wa*4 + k], pw[k], pm[k]);
         end
      end
      m_rbusy = racc;
      if (wacc)             m_wph = 1;
      else if (m_wph == 1)  m_wph = 2;
      else                  m_wph = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0);
   endtask

   task automatic do_reset(input int n);
      @(negedge clk);
      rst  = 1'b1;
      rd_n = 1'b1;
      wr_n = 1'b1;
      for (int i = 0; i < 4; i++) slot_v[i] = 1'b0;
      m_rbusy = 1'b0;
      m_wph   = 0;
      for (int i = 0; i < n; i++) @(negedge clk);
      checks++;
      if (rd_valid !== 1'b0) begin
         errors++;
         $display("FAIL R11: rd_valid=%b during reset expected 0", rd_valid);
      end
      rst = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) slot_v[i] = 1'b0;
      // reset state: R11
      cur_req = "R11";
      do_reset(4);

      // fill every burst with full masks; beat order and data timing: R2, R6
      cur_req = "R2/R6";
      mask_mode = 0;
      for (int a = 0; a < DEPTH; a++) begin
         step(1'b0, 0, 1'b1, a);
         step(1'b0, 0, 1'b0, 0);
      end
      idle(3);
      for (int a = 0; a < 8; a++) begin
         step(1'b1, a, 1'b0, 0);
         step(1'b0, 0, 1'b0, 0);
      end
      idle(3);

      // R1: same-edge read and write of one burst, read sees old data
      cur_req = "R1";
      step(1'b1, 3, 1'b1, 3);
      step(1'b0, 0, 1'b0, 0);
      step(1'b1, 3, 1'b0, 0);
      idle(4);

      // R3: read on the busy edge is dropped, next one runs back to back
      cur_req = "R3";
      step(1'b1, 4, 1'b0, 0);
      step(1'b1, 5, 1'b0, 0);
      step(1'b1, 6, 1'b0, 0);
      idle(4);

      // R4: write on the busy edge is dropped, burst 11 keeps its data
      cur_req = "R4";
      step(1'b0, 0, 1'b1, 10);
      step(1'b0, 0, 1'b1, 11);
      idle(4);
      step(1'b1, 11, 1'b0, 0);
      step(1'b0, 0, 1'b0, 0);
      step(1'b1, 10, 1'b0, 0);
      idle(4);

      // R5: isolated read, exact valid window
      cur_req = "R5";
      step(1'b1, 20, 1'b0, 0);
      idle(5);

      // R7: partial lane masks, read after idle
      cur_req = "R7";
      mask_mode = 1;
      step(1'b0, 0, 1'b1, 12);
      idle(3);
      step(1'b1, 12, 1'b0, 0);
      idle(4);

      // R8: read immediately after a full write to the same burst
      cur_req = "R8";
      mask_mode = 0;
      step(1'b0, 0, 1'b1, 13);
      step(1'b1, 13, 1'b0, 0);
      step(1'b0, 0, 1'b1, 13);
      step(1'b1, 13, 1'b0, 0);
      step(1'b1, 13, 1'b1, 14);
      step(1'b0, 0, 1'b0, 0);
      step(1'b1, 14, 1'b0, 0);
      idle(4);

      // R9: partial masks forwarded lane by lane from held bursts
      cur_req = "R9";
      mask_mode = 1;
      step(1'b0, 0, 1'b1, 15);
      step(1'b1, 15, 1'b0, 0);
      step(1'b0, 0, 1'b1, 15);
      step(1'b1, 15, 1'b0, 0);
      step(1'b0, 0, 1'b1, 15);
      step(1'b1, 15, 1'b0, 0);
      step(1'b1, 15, 1'b0, 0);
      idle(4);

      // R11: reset during a read burst; pending write survives
      cur_req = "R11";
      step(1'b0, 0, 1'b1, 16);
      idle(3);
      step(1'b1, 16, 1'b0, 0);
      do_reset(3);
      step(1'b1, 16, 1'b0, 0);
      idle(4);

      // constrained random traffic over a small address window: R8, R9
      cur_req = "R8/R9 random";
      mask_mode = 1;
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 2) == 1, int'($urandom % 8),
              ($urandom % 2) == 1, int'($urandom % 8));
      end
      idle(4);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule